// File: doc/BRIEF.md
# Hot-Swap Sequencing and Retry Controller

This block is the digital sequencer for a hot-swap pass switch. It watches a power-on-reset flag, undervoltage and overvoltage comparator flags, current-limit and power-limit activity flags and a breaker trip flag. From these it produces a two-bit gate-drive command for the analog gate driver. The command has three levels: strong pulldown, weak pulldown and conduct/regulate. Three delays that would otherwise come from an external timing capacitor are modelled by one shared cycle counter. These are the insertion delay, the fault timeout and the restart back-off.

After a fault the controller does one of two things. It either locks the switch off until the enable (undervoltage) input is pulsed or power is removed, or it backs off and tries again. The number of retries is limited by a 3-bit selection.

The sequencer has seven states:
- UNPOWERED: gate strongly off.
- INSERT: settling delay.
- ARM_WAIT: waiting for the input to be in range.
- CONDUCT: gate on.
- BREAKER: breaker trip handling.
- BACKOFF: restart delay.
- LOCKOUT: latched off.

The transitions are:
- power-good: UNPOWERED→INSERT.
- insert-done: INSERT→CONDUCT, or INSERT→ARM_WAIT while the input is out of range.
- input-ok: ARM_WAIT→CONDUCT.
- input-lost: CONDUCT→ARM_WAIT.
- trip: CONDUCT→BREAKER.
- timeout: CONDUCT or BREAKER→BACKOFF, or →LOCKOUT when no retry is granted.
- backoff-done: BACKOFF→CONDUCT or ARM_WAIT.
- enable-pulse: LOCKOUT→ARM_WAIT.
- power-loss: any state→UNPOWERED.

Top module: `hotswap_seq_ctrl`

## Requirements
- R1: While `por_ok` is low the gate command is 00 (strong off) from the next clock on, and reset leaves the gate at 00 with all fault flags low.
- R2: When `por_ok` rises, the gate is held at 01 (weak off) for the entry cycle plus INSERT_CYC counting cycles, whatever `uv_flag` and `ov_flag` do in that time.
- R3: At the end of insertion the gate goes to 10 (on) at once if both `uv_flag` and `ov_flag` are low. Otherwise it stays at 01 until both are low, and then goes to 10 on the next clock.
- R4: The fault timer advances only in cycles where `ilim_act` or `plim_act` is high while conducting. A cycle with both low restarts it, so FAULT_CYC consecutive limiting cycles are needed for a timeout.
- R5: On a fault timeout the gate goes to 01 and `flt_timeout` rises. `flt_timeout` falls when the gate next turns on or power is lost.
- R6: A breaker trip while conducting gives gate 00 on the next clock and sets `flt_breaker`. The gate moves to 01 the clock after `cb_trip` falls. FAULT_CYC cycles after the trip, the same retry decision as for a timeout is taken.
- R7: An undervoltage or overvoltage flag never lets the gate be 10 on the next clock. While conducting, either flag gives 01.
- R8: With `retry_en` low, a fault sets `latched_off` and holds the gate at 01. Only a high `uv_flag` (enable pulse) or low `por_ok` clears it.
- R9: With a retry granted, the gate stays at 01 for 8×RESTART_CYC cycles after the fault. The next clock then turns it on if the input is in range.
- R10: `retry_sel` allows 0 retries (0), 1 (1), 2 (2), 4 (3), 8 (4) or 16 (5), and 6 or 7 means unlimited. When the allowance is used up, the next fault latches off exactly as in R8.
- R11: The retry allowance is reloaded from `retry_sel` in every cycle in which `uv_flag` is high or the controller is unpowered.
- R12: The gate command is always one of 00, 01 or 10, never 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| por_ok | input | 1 | Supply is above the power-on-reset threshold |
| uv_flag | input | 1 | Input below the undervoltage threshold or enable low |
| ov_flag | input | 1 | Input above the overvoltage threshold |
| ilim_act | input | 1 | Current limiting is active |
| plim_act | input | 1 | Power limiting is active |
| cb_trip | input | 1 | Breaker comparator tripped |
| retry_en | input | 1 | 1 = retry after a fault, 0 = latch off |
| retry_sel | input | 3 | Retry allowance selection (see R10) |
| gate_cmd | output | 2 | 00 strong off, 01 weak off, 10 on |
| flt_timeout | output | 1 | Last shutdown was a limiting timeout |
| flt_breaker | output | 1 | Last shutdown was a breaker trip |
| latched_off | output | 1 | Controller is locked off |

## Verification
Several properties are checked by assertions on every cycle. These are the legal gate encoding, strong-off without power-on reset and never-on after an input-range flag. They also cover strong-off after a trip while conducting, that a timeout flag can only follow a limiting cycle, that a lockout holds without an enable pulse, and that retries are only consumed while allowance remains. Other behaviour depends on exact cycle counts, so only the bench scenarios can show it: the insertion length, consecutive limit counting with restart, the back-off duration, and the retry allowance for each selection code including unlimited and refill on an enable pulse.

// File: rtl/hs_pkg.sv
package hs_pkg;

    typedef enum logic [1:0] {
        GATE_STRONG_OFF = 2'b00,
        GATE_WEAK_OFF   = 2'b01,
        GATE_ON         = 2'b10
    } gate_cmd_e;

    typedef enum logic [2:0] {
        ST_UNPOWERED,
        ST_INSERT,
        ST_ARM_WAIT,
        ST_CONDUCT,
        ST_BREAKER,
        ST_BACKOFF,
        ST_LOCKOUT
    } seq_state_e;

    localparam int SEL_W   = 3;
    localparam int QUOTA_W = 5;

    // selection code -> finite retry allowance (codes 6/7 are unlimited)
    function automatic logic [QUOTA_W-1:0] retry_quota(input logic [SEL_W-1:0] sel);
        logic [QUOTA_W-1:0] q;
        if (sel == '0)
            q = '0;
        else if (sel <= SEL_W'(5))
            q = QUOTA_W'(1) << (sel - SEL_W'(1));
        else
            q = '0;
        return q;
    endfunction

endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en)
            cnt <= cnt + CNT_W'(1);
    end

    assign expired = en && (cnt == limit - CNT_W'(1));

    // R4: the count stays inside the active window of the current phase
    p_cnt_in_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr) |-> (cnt < limit));

endmodule

// File: rtl/hs_retry_budget.sv
module hs_retry_budget
    import hs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             consume,
    input  logic [SEL_W-1:0] sel,
    output logic             may_retry
);
    logic [QUOTA_W-1:0] left;
    logic               unlimited;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left      <= '0;
            unlimited <= 1'b0;
        end else if (reload) begin
            left      <= retry_quota(sel);
            unlimited <= (sel >= SEL_W'(6));
        end else if (consume && !unlimited && (left != '0)) begin
            left <= left - QUOTA_W'(1);
        end
    end

    assign may_retry = unlimited || (left != '0);

    // R10: a retry is only taken while allowance remains
    p_consume_allowed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> may_retry);

endmodule

// File: rtl/hs_seq_fsm.sv
module hs_seq_fsm
    import hs_pkg::*;
#(
    parameter int               CNT_W   = 8,
    parameter logic [CNT_W-1:0] LIM_INS = CNT_W'(4),
    parameter logic [CNT_W-1:0] LIM_FLT = CNT_W'(3),
    parameter logic [CNT_W-1:0] LIM_RST = CNT_W'(16)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             por_ok,
    input  logic             uv,
    input  logic             ov,
    input  logic             lim,
    input  logic             cb,
    input  logic             retry_en,
    input  logic             may_retry,
    input  logic             tmr_expired,
    output logic             tmr_clr,
    output logic             tmr_en,
    output logic [CNT_W-1:0] tmr_limit,
    output logic             budget_reload,
    output logic             budget_consume,
    output logic [1:0]       gate_cmd,
    output logic             flt_timeout,
    output logic             flt_breaker,
    output logic             latched_off
);
    seq_state_e state, state_nxt;
    logic       fault_decide;
    logic       out_of_range;

    assign out_of_range = uv || ov;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_UNPOWERED;
        else
            state <= state_nxt;
    end

    // next-state logic
    always_comb begin
        state_nxt    = state;
        fault_decide = 1'b0;
        if (!por_ok) begin
            state_nxt = ST_UNPOWERED;                       // power-loss
        end else begin
            unique case (state)
                ST_UNPOWERED: state_nxt = ST_INSERT;        // power-good
                ST_INSERT: begin
                    if (tmr_expired)                        // insert-done
                        state_nxt = out_of_range ? ST_ARM_WAIT : ST_CONDUCT;
                end
                ST_ARM_WAIT: begin
                    if (!out_of_range)                      // input-ok
                        state_nxt = ST_CONDUCT;
                end
                ST_CONDUCT: begin
                    if (cb)                                 // trip
                        state_nxt = ST_BREAKER;
                    else if (out_of_range)                  // input-lost
                        state_nxt = ST_ARM_WAIT;
                    else if (tmr_expired)                   // timeout
                        fault_decide = 1'b1;
                end
                ST_BREAKER: begin
                    if (tmr_expired)
                        fault_decide = 1'b1;
                end
                ST_BACKOFF: begin
                    if (tmr_expired)                        // backoff-done
                        state_nxt = out_of_range ? ST_ARM_WAIT : ST_CONDUCT;
                end
                ST_LOCKOUT: begin
                    if (uv)                                 // enable-pulse
                        state_nxt = ST_ARM_WAIT;
                end
                default: state_nxt = ST_UNPOWERED;
            endcase
            if (fault_decide)
                state_nxt = (retry_en && may_retry) ? ST_BACKOFF : ST_LOCKOUT;
        end
    end

    // shared timer and retry allowance control
    always_comb begin
        tmr_clr   = (state_nxt != state) || ((state == ST_CONDUCT) && !lim);
        tmr_en    = 1'b0;
        tmr_limit = LIM_FLT;
        unique case (state)
            ST_INSERT:  begin tmr_en = 1'b1; tmr_limit = LIM_INS; end
            ST_CONDUCT: begin tmr_en = lim;  tmr_limit = LIM_FLT; end
            ST_BREAKER: begin tmr_en = 1'b1; tmr_limit = LIM_FLT; end
            ST_BACKOFF: begin tmr_en = 1'b1; tmr_limit = LIM_RST; end
            default:    begin tmr_en = 1'b0; tmr_limit = LIM_FLT; end
        endcase
    end

    assign budget_reload  = (state == ST_UNPOWERED) || uv;
    assign budget_consume = fault_decide && (state_nxt == ST_BACKOFF);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_cmd    <= GATE_STRONG_OFF;
            flt_timeout <= 1'b0;
            flt_breaker <= 1'b0;
            latched_off <= 1'b0;
        end else begin
            unique case (state_nxt)
                ST_UNPOWERED: gate_cmd <= GATE_STRONG_OFF;
                ST_CONDUCT:   gate_cmd <= GATE_ON;
                ST_BREAKER:   gate_cmd <= cb ? GATE_STRONG_OFF : GATE_WEAK_OFF;
                default:      gate_cmd <= GATE_WEAK_OFF;
            endcase
            if ((state_nxt == ST_UNPOWERED) || (state_nxt == ST_CONDUCT)) begin
                flt_timeout <= 1'b0;
                flt_breaker <= 1'b0;
            end else begin
                if ((state == ST_CONDUCT) && fault_decide)
                    flt_timeout <= 1'b1;
                if ((state == ST_CONDUCT) && (state_nxt == ST_BREAKER))
                    flt_breaker <= 1'b1;
            end
            latched_off <= (state_nxt == ST_LOCKOUT);
        end
    end

    p_por_strong_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (gate_cmd == GATE_STRONG_OFF));

    p_range_blocks_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |=> (gate_cmd != GATE_ON));

    p_trip_strong_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_cmd == GATE_ON && cb && por_ok) |=> (gate_cmd == GATE_STRONG_OFF));

    p_timeout_needs_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flt_timeout) |-> $past(lim));

    p_lockout_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (latched_off && por_ok && !uv) |=> latched_off);

    p_gate_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        gate_cmd != 2'b11);

endmodule

// File: rtl/hotswap_seq_ctrl.sv
module hotswap_seq_ctrl
    import hs_pkg::*;
#(
    parameter int INSERT_CYC  = 1024,
    parameter int FAULT_CYC   = 256,
    parameter int RESTART_CYC = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       por_ok,
    input  logic       uv_flag,
    input  logic       ov_flag,
    input  logic       ilim_act,
    input  logic       plim_act,
    input  logic       cb_trip,
    input  logic       retry_en,
    input  logic [2:0] retry_sel,
    output logic [1:0] gate_cmd,
    output logic       flt_timeout,
    output logic       flt_breaker,
    output logic       latched_off
);
    localparam int RESTART_TOTAL = 8 * RESTART_CYC;
    localparam int MAX_AB        = (INSERT_CYC > FAULT_CYC) ? INSERT_CYC : FAULT_CYC;
    localparam int TMAX          = (MAX_AB > RESTART_TOTAL) ? MAX_AB : RESTART_TOTAL;
    localparam int CNT_W         = $clog2(TMAX + 1);

    localparam logic [CNT_W-1:0] LIM_INS = CNT_W'(INSERT_CYC);
    localparam logic [CNT_W-1:0] LIM_FLT = CNT_W'(FAULT_CYC);
    localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(RESTART_TOTAL);

    logic             tmr_clr, tmr_en, tmr_expired;
    logic [CNT_W-1:0] tmr_limit;
    logic             budget_reload, budget_consume, may_retry;

    hs_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .en      (tmr_en),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    hs_retry_budget u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .reload    (budget_reload),
        .consume   (budget_consume),
        .sel       (retry_sel),
        .may_retry (may_retry)
    );

    hs_seq_fsm #(
        .CNT_W   (CNT_W),
        .LIM_INS (LIM_INS),
        .LIM_FLT (LIM_FLT),
        .LIM_RST (LIM_RST)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .por_ok         (por_ok),
        .uv             (uv_flag),
        .ov             (ov_flag),
        .lim            (ilim_act || plim_act),
        .cb             (cb_trip),
        .retry_en       (retry_en),
        .may_retry      (may_retry),
        .tmr_expired    (tmr_expired),
        .tmr_clr        (tmr_clr),
        .tmr_en         (tmr_en),
        .tmr_limit      (tmr_limit),
        .budget_reload  (budget_reload),
        .budget_consume (budget_consume),
        .gate_cmd       (gate_cmd),
        .flt_timeout    (flt_timeout),
        .flt_breaker    (flt_breaker),
        .latched_off    (latched_off)
    );

endmodule

// File: tb/tb_hotswap_seq_ctrl.sv
module tb_hotswap_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int INS = 4;
    localparam int FLT = 3;
    localparam int RST = 2;
    localparam int BACKOFF = 8 * RST;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       por_ok = 1'b0, uv_flag = 1'b0, ov_flag = 1'b0;
    logic       ilim_act = 1'b0, plim_act = 1'b0, cb_trip = 1'b0;
    logic       retry_en = 1'b0;
    logic [2:0] retry_sel = 3'd0;
    logic [1:0] gate_cmd;
    logic       flt_timeout, flt_breaker, latched_off;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hotswap_seq_ctrl #(.INSERT_CYC(INS), .FAULT_CYC(FLT), .RESTART_CYC(RST)) dut (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .ilim_act(ilim_act), .plim_act(plim_act), .cb_trip(cb_trip),
        .retry_en(retry_en), .retry_sel(retry_sel), .gate_cmd(gate_cmd),
        .flt_timeout(flt_timeout), .flt_breaker(flt_breaker), .latched_off(latched_off)
    );

    // {por, uv, ov, lim, cb, gate[1:0], latched}; latch mode, checked one cycle each
    localparam logic [7:0] TBL [25] = '{
        8'b0_0_0_0_0_00_0, 8'b1_0_0_0_0_01_0, 8'b1_0_0_0_0_01_0, 8'b1_1_0_0_0_01_0,
        8'b1_1_0_0_0_01_0, 8'b1_0_0_0_0_10_0, 8'b1_0_0_1_0_10_0, 8'b1_0_0_1_0_10_0,
        8'b1_0_0_0_0_10_0, 8'b1_0_0_1_0_10_0, 8'b1_0_0_1_0_10_0, 8'b1_0_0_1_0_01_1,
        8'b1_0_0_0_0_01_1, 8'b1_1_0_0_0_01_0, 8'b1_0_0_0_0_10_0, 8'b1_1_0_0_0_01_0,
        8'b1_0_0_0_0_10_0, 8'b1_0_1_0_0_01_0, 8'b1_0_0_0_0_10_0, 8'b1_0_0_0_1_00_0,
        8'b1_0_0_0_1_00_0, 8'b1_0_0_0_0_01_0, 8'b1_0_0_0_0_01_1, 8'b1_0_0_0_0_01_1,
        8'b0_0_0_0_0_00_0
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input logic p, input logic u, input logic o,
                        input logic il, input logic pl, input logic c);
        por_ok = p; uv_flag = u; ov_flag = o; ilim_act = il; plim_act = pl; cb_trip = c;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) tick(1, 0, 0, 0, 0, 0);
    endtask

    task automatic power_up();
        for (int k = 0; k < INS + 1; k++) tick(1, 0, 0, 0, 0, 0);
    endtask

    task automatic limit_fault(input logic use_plim);
        for (int k = 0; k < FLT; k++) tick(1, 0, 0, !use_plim, use_plim, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 R12: reset state
        chk("R1 reset gate", {6'd0, gate_cmd}, 8'd0);
        chk("R1 reset flags", {5'd0, flt_timeout, flt_breaker, latched_off}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R12 in latch mode
        for (int i = 0; i < 25; i++) begin
            tick(TBL[i][7], TBL[i][6], TBL[i][5], TBL[i][4], 1'b0, TBL[i][3]);
            chk($sformatf("R2_R8 table row %0d gate", i), {6'd0, gate_cmd}, {6'd0, TBL[i][2:1]});
            chk($sformatf("R8 table row %0d latched", i), {7'd0, latched_off}, {7'd0, TBL[i][0]});
        end

        // R2 R3: insertion with input held out of range, then wait
        retry_en = 1'b1; retry_sel = 3'd1;
        for (int k = 0; k < INS + 1; k++) tick(1, 1, 0, 0, 0, 0);
        chk("R2 weak off after insertion uv high", {6'd0, gate_cmd}, 8'd1);
        for (int k = 0; k < 3; k++) tick(1, 1, 0, 0, 0, 0);
        chk("R3 waits for uv", {6'd0, gate_cmd}, 8'd1);
        tick(1, 0, 0, 0, 0, 0);
        chk("R3 on when uv clears", {6'd0, gate_cmd}, 8'd2);

        // R4 R5 R9: timeout with one retry
        tick(1, 0, 0, 1, 0, 0); tick(1, 0, 0, 1, 0, 0);
        chk("R4 still on before timeout", {6'd0, gate_cmd}, 8'd2);
        tick(1, 0, 0, 1, 0, 0);
        chk("R5 weak off on timeout", {6'd0, gate_cmd}, 8'd1);
        chk("R5 timeout flag", {7'd0, flt_timeout}, 8'd1);
        chk("R9 not latched with retry", {7'd0, latched_off}, 8'd0);
        idle(BACKOFF - 1);
        chk("R9 still off before backoff end", {6'd0, gate_cmd}, 8'd1);
        idle(1);
        chk("R9 on after backoff", {6'd0, gate_cmd}, 8'd2);
        chk("R5 timeout flag clears", {7'd0, flt_timeout}, 8'd0);

        // R10: allowance of one used, next fault latches; R8 holds
        limit_fault(1'b1);
        chk("R10 one retry exhausted", {7'd0, latched_off}, 8'd1);
        idle(20);
        chk("R8 lockout holds", {7'd0, latched_off}, 8'd1);
        chk("R8 lockout gate", {6'd0, gate_cmd}, 8'd1);

        // R11: enable pulse refills allowance
        tick(1, 1, 0, 0, 0, 0);
        chk("R11 enable pulse clears lockout", {7'd0, latched_off}, 8'd0);
        tick(1, 0, 0, 0, 0, 0);
        chk("R11 on after enable pulse", {6'd0, gate_cmd}, 8'd2);
        limit_fault(1'b0);
        chk("R11 refilled retry granted", {7'd0, latched_off}, 8'd0);
        idle(BACKOFF);
        chk("R11 back on after retry", {6'd0, gate_cmd}, 8'd2);

        // R6: breaker trip, allowance now spent -> lockout
        tick(1, 0, 0, 0, 0, 1);
        chk("R6 strong off on trip", {6'd0, gate_cmd}, 8'd0);
        chk("R6 breaker flag", {7'd0, flt_breaker}, 8'd1);
        tick(1, 0, 0, 0, 0, 1);
        chk("R6 strong while tripped", {6'd0, gate_cmd}, 8'd0);
        tick(1, 0, 0, 0, 0, 0);
        chk("R6 weak after trip clears", {6'd0, gate_cmd}, 8'd1);
        tick(1, 0, 0, 0, 0, 0);
        chk("R6 R10 breaker period ends in lockout", {7'd0, latched_off}, 8'd1);

        // R1: power loss clears everything
        tick(0, 0, 0, 0, 0, 0);
        chk("R1 strong off on power loss", {6'd0, gate_cmd}, 8'd0);
        chk("R1 flags cleared", {5'd0, flt_timeout, flt_breaker, latched_off}, 8'd0);

        // R1: power loss during insertion
        tick(1, 0, 0, 0, 0, 0); tick(1, 0, 0, 0, 0, 0);
        tick(0, 0, 0, 0, 0, 0);
        chk("R1 power loss in insertion", {6'd0, gate_cmd}, 8'd0);

        // R10: code 0 = no retries
        retry_sel = 3'd0;
        power_up();
        chk("R10 up with sel 0", {6'd0, gate_cmd}, 8'd2);
        limit_fault(1'b0);
        chk("R10 sel 0 latches at once", {7'd0, latched_off}, 8'd1);

        // R10: code 6 = unlimited
        tick(0, 0, 0, 0, 0, 0);
        retry_sel = 3'd6;
        power_up();
        for (int n = 0; n < 3; n++) begin
            limit_fault(n[0]);
            chk("R10 unlimited never latches", {7'd0, latched_off}, 8'd0);
            idle(BACKOFF);
            chk("R10 unlimited back on", {6'd0, gate_cmd}, 8'd2);
        end

        // R10: code 2 = two retries
        tick(0, 0, 0, 0, 0, 0);
        retry_sel = 3'd2;
        power_up();
        for (int n = 0; n < 2; n++) begin
            limit_fault(1'b0);
            chk("R10 sel 2 retry granted", {7'd0, latched_off}, 8'd0);
            idle(BACKOFF);
        end
        limit_fault(1'b0);
        chk("R10 sel 2 third fault latches", {7'd0, latched_off}, 8'd1);

        // R7: overvoltage while on
        tick(0, 0, 0, 0, 0, 0);
        power_up();
        tick(1, 0, 1, 0, 0, 0);
        chk("R7 overvoltage weak off", {6'd0, gate_cmd}, 8'd1);

        finish_run();
    end
endmodule